// File: doc/BRIEF.md
# Comparator Trip-Code Sweep Sequencer

This block searches for the reference-DAC code at which an analog comparator starts to trip against a steady input voltage. It begins at the top of the DAC range, or at a code supplied by the caller, and walks the code downward one step at a time. Each step gives the DAC time to settle, pulses a clear into the comparator's output latch, waits a programmable number of cycles, and then samples the latch. The first code at which the latch comes back set is recorded as the trip code.

An optional check pass then raises the code by one, repeats the settle, clear and wait, and requires the latch to stay clear. This confirms that the recorded code sits on the boundary. The results stay on the outputs until the next start. The DAC and comparator are outside the block: the block only drives the code and the clear, and reads back the latch.

Top module: `cmp_trip_cal`

## Requirements
- R1: After reset, `dac_code` is 0xFFF, `latch_clr` is low, and `done`, `found`, `verify_err` and `trip_code` are all zero.
- R2: A `start` pulse while idle loads `dac_code` with `start_code` when `use_start_code` is 1, and with 0xFFF otherwise. The first code tested is the loaded code minus one. A start also clears `done`, `found`, `verify_err` and `trip_code`.
- R3: Each sweep iteration lowers `dac_code` by exactly one. One `latch_clr` pulse is issued per code tested.
- R4: `dac_code` holds its new value for S = max(`settle_cycles`,1) cycles before `latch_clr` rises. `latch_clr` is high for exactly one cycle. During the downward sweep, successive clear pulses are S + W + 3 cycles apart, where W = max(`wait_cycles`,1).
- R5: `latch_q` is tested W cycles after the clear pulse. If it is high and `verify_en` is 0, the sweep ends with `done`=1, `found`=1, and `trip_code` and `dac_code` equal to the tested code.
- R6: If code 0 is tested without a trip, or the loaded code is 0, the sweep ends with `done`=1, `found`=0, `verify_err`=0 and `dac_code`=0.
- R7: With `verify_en`=1, a trip stores the code in `trip_code` and sets `dac_code` to `trip_code`+1. The block then runs the settle, clear and wait again. If `latch_q` is then low, it ends with `found`=1.
- R8: If `latch_q` is high at the end of the check pass, the block ends with `found`=0 and `verify_err`=1. `trip_code` keeps the candidate code.
- R9: A `start` pulse during a sweep has no effect. `done` and the result outputs hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep (taken only while idle) |
| use_start_code | input | 1 | 1: begin from `start_code`; 0: begin from full scale |
| start_code | input | 12 | Caller-supplied starting code |
| verify_en | input | 1 | Enable the one-step-up check pass |
| settle_cycles | input | 16 | DAC settling time in cycles (0 treated as 1) |
| wait_cycles | input | 16 | Wait after the clear before testing the latch (0 treated as 1) |
| latch_q | input | 1 | Comparator latch status |
| dac_code | output | 12 | Code driven to the reference DAC |
| latch_clr | output | 1 | One-cycle clear strobe to the comparator latch |
| done | output | 1 | Sweep finished; held until the next start |
| found | output | 1 | A trip code was found (and confirmed, if checked) |
| verify_err | output | 1 | The check pass saw the latch set one code above |
| trip_code | output | 12 | Code at which the latch first tripped |

## Verification
A sweep's results are due one cycle after its final latch test. The bench therefore samples on falling edges and waits for `done`, never for a fixed delay. The clear strobe is due S cycles after each code change, and the next strobe S + W + 3 cycles after that. A falling-edge monitor measures both gaps against values computed from the programmed counts. The comparator model sets its latch one cycle after a clear whenever the code is at or below its threshold. From this, the bench works out the trip code, the check outcome and the final DAC code without looking inside the design.

// File: rtl/cmp_trip_cal.sv
module cmp_trip_cal #(
  parameter int DAC_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             use_start_code,
  input  logic [DAC_W-1:0] start_code,
  input  logic             verify_en,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic [CNT_W-1:0] wait_cycles,
  input  logic             latch_q,
  output logic [DAC_W-1:0] dac_code,
  output logic             latch_clr,
  output logic             done,
  output logic             found,
  output logic             verify_err,
  output logic [DAC_W-1:0] trip_code
);

  localparam logic [DAC_W-1:0] CODE_MAX = '1;
  localparam logic [DAC_W-1:0] ONE      = DAC_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_STEP, S_SETTLE, S_CLEAR, S_WAIT, S_TEST} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             checking;
  logic             busy;
  logic             cnt_last;

  assign busy      = (state != S_IDLE);
  assign cnt_last  = (cnt <= CNT_ONE);
  assign latch_clr = (state == S_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      dac_code   <= CODE_MAX;
      cnt        <= '0;
      checking   <= 1'b0;
      done       <= 1'b0;
      found      <= 1'b0;
      verify_err <= 1'b0;
      trip_code  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          dac_code   <= use_start_code ? start_code : CODE_MAX;
          done       <= 1'b0;
          found      <= 1'b0;
          verify_err <= 1'b0;
          trip_code  <= '0;
          checking   <= 1'b0;
          state      <= S_STEP;
        end
        S_STEP: if (dac_code == '0) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end else begin
          dac_code <= dac_code - ONE;
          cnt      <= settle_cycles;
          state    <= S_SETTLE;
        end
        S_SETTLE: if (cnt_last) state <= S_CLEAR;
                  else          cnt   <= cnt - CNT_ONE;
        S_CLEAR: begin
          cnt   <= wait_cycles;
          state <= S_WAIT;
        end
        S_WAIT: if (cnt_last) state <= S_TEST;
                else          cnt   <= cnt - CNT_ONE;
        S_TEST: if (checking) begin
          done       <= 1'b1;
          found      <= !latch_q;
          verify_err <= latch_q;
          state      <= S_IDLE;
        end else if (latch_q) begin
          trip_code <= dac_code;
          if (verify_en) begin
            checking <= 1'b1;
            dac_code <= dac_code + ONE;
            cnt      <= settle_cycles;
            state    <= S_SETTLE;
          end else begin
            found <= 1'b1;
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end else begin
          state <= S_STEP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4
  clr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clr |=> !latch_clr);

  // R3
  code_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (dac_code == $past(dac_code) || dac_code == $past(dac_code) - ONE
              || dac_code == $past(dac_code) + ONE));

  // R8
  verify_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verify_err |-> !found);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(trip_code) && $stable(found)));

  // R5
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state == S_TEST || state == S_STEP));

endmodule

// File: tb/cmp_trip_cal_bench.sv
`timescale 1ns/1ps
module cmp_trip_cal_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        use_start_code = 1'b0;
  logic [11:0] start_code = '0;
  logic        verify_en = 1'b0;
  logic [15:0] settle_cycles = 16'd1;
  logic [15:0] wait_cycles = 16'd1;
  logic        latch_q;
  logic [11:0] dac_code;
  logic        latch_clr;
  logic        done;
  logic        found;
  logic        verify_err;
  logic [11:0] trip_code;

  always #2 clk = ~clk;

  cmp_trip_cal u_cmp_trip_cal (
    .clk(clk), .rst_n(rst_n), .start(start), .use_start_code(use_start_code),
    .start_code(start_code), .verify_en(verify_en), .settle_cycles(settle_cycles),
    .wait_cycles(wait_cycles), .latch_q(latch_q), .dac_code(dac_code),
    .latch_clr(latch_clr), .done(done), .found(found), .verify_err(verify_err),
    .trip_code(trip_code)
  );

  int thr = 0;
  bit never = 1'b0;
  bit stuck = 1'b0;
  logic lat;
  always_ff @(posedge clk) begin
    if (!rst_n)         lat <= 1'b0;
    else if (latch_clr) lat <= 1'b0;
    else if (stuck || (!never && int'(dac_code) <= thr)) lat <= 1'b1;
  end
  assign latch_q = lat;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  int exp_gap = 1;
  int exp_period = 0;
  int gap = 0;
  int since_clr = 0;
  int clr_count = 0;
  int gap_err = 0;
  int per_err = 0;
  int wide_err = 0;
  logic [11:0] prev_code = '0;
  logic prev_clr = 1'b0;
  always @(negedge clk) begin
    if (dac_code != prev_code) gap = 0;
    else gap++;
    since_clr++;
    if (latch_clr) begin
      if (prev_clr) wide_err++;
      if (gap != exp_gap) gap_err++;
      if (clr_count > 0 && exp_period != 0 && since_clr != exp_period) per_err++;
      clr_count++;
      since_clr = 0;
    end
    prev_code = dac_code;
    prev_clr  = latch_clr;
  end

  typedef struct packed {
    logic [11:0] sc;
    logic        use_sc;
    logic        ver;
    logic [15:0] st;
    logic [15:0] wt;
    logic [11:0] th;
    logic        nev;
    logic        stk;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{12'h000, 1'b0, 1'b0, 16'd2, 16'd2, 12'hF00, 1'b0, 1'b0},
    '{12'h400, 1'b1, 1'b1, 16'd1, 16'd1, 12'h123, 1'b0, 1'b0},
    '{12'h050, 1'b1, 1'b1, 16'd1, 16'd1, 12'h000, 1'b1, 1'b0},
    '{12'h300, 1'b1, 1'b1, 16'd2, 16'd1, 12'h000, 1'b0, 1'b1},
    '{12'h300, 1'b1, 1'b0, 16'd1, 16'd2, 12'h000, 1'b0, 1'b1},
    '{12'h010, 1'b1, 1'b1, 16'd1, 16'd1, 12'h020, 1'b0, 1'b0},
    '{12'h008, 1'b1, 1'b1, 16'd1, 16'd1, 12'h000, 1'b0, 1'b0},
    '{12'h000, 1'b1, 1'b1, 16'd1, 16'd1, 12'h005, 1'b0, 1'b0},
    '{12'h020, 1'b1, 1'b0, 16'd0, 16'd0, 12'h011, 1'b0, 1'b0},
    '{12'h000, 1'b0, 1'b0, 16'd0, 16'd0, 12'h000, 1'b1, 1'b0},
    '{12'hFFF, 1'b1, 1'b1, 16'd3, 16'd2, 12'hFFE, 1'b0, 1'b0}
  };

  task automatic apply(input vec_t v);
    use_start_code = v.use_sc;
    start_code     = v.sc;
    verify_en      = v.ver;
    settle_cycles  = v.st;
    wait_cycles    = v.wt;
    thr            = int'(v.th);
    never          = v.nev;
    stuck          = v.stk;
    exp_gap        = (v.st == 0) ? 1 : int'(v.st);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40000 && !done; i++) @(negedge clk);
  endtask

  task automatic expect_of(input vec_t v, output bit e_found, output bit e_verr,
                           output int e_trip, output int e_dac);
    int s;
    int cand;
    bit has;
    s = v.use_sc ? int'(v.sc) : 'hFFF;
    e_found = 0; e_verr = 0; e_trip = 0; e_dac = 0; has = 0; cand = 0;
    if (s > 0) begin
      if (v.stk) begin cand = s - 1; has = 1; end
      else if (!v.nev) begin cand = (s - 1 <= int'(v.th)) ? s - 1 : int'(v.th); has = 1; end
    end
    if (has) begin
      e_trip = cand;
      if (v.ver) begin
        e_dac = cand + 1;
        if (v.stk || (cand + 1 <= int'(v.th))) e_verr = 1; else e_found = 1;
      end else begin
        e_dac = cand;
        e_found = 1;
      end
    end
  endtask

  initial begin
    bit ef;
    bit ev;
    int et;
    int ed;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dac_code == 12'hFFF, "R1 dac_code", dac_code, 'hFFF);
    check(!latch_clr && !done && !found && !verify_err, "R1 flags",
          {latch_clr, done, found, verify_err}, 0);
    check(trip_code == 0, "R1 trip_code", trip_code, 0);
    @(negedge clk) rst_n = 1'b1;

    // R2 R5 R6 R7 R8 vector walk
    for (int k = 0; k < NV; k++) begin
      apply(VECS[k]);
      expect_of(VECS[k], ef, ev, et, ed);
      pulse_start();
      wait_done();
      check(done == 1'b1, "R5/R6 done", done, 1);
      check(found == ef, "R5/R7 found", found, ef);
      check(verify_err == ev, "R8 verify_err", verify_err, ev);
      check(int'(trip_code) == et, "R2/R5 trip_code", trip_code, et);
      check(int'(dac_code) == ed, "R6/R7 dac_code", dac_code, ed);
    end
    check(gap_err == 0, "R4 settle before clear", gap_err, 0);
    check(wide_err == 0, "R4 clear width", wide_err, 0);

    // R3 R4 iteration pacing and unit steps
    apply('{12'h040, 1'b1, 1'b0, 16'd5, 16'd3, 12'h030, 1'b0, 1'b0});
    exp_period = 5 + 3 + 3;
    clr_count = 0; gap_err = 0; per_err = 0;
    pulse_start();
    wait_done();
    check(trip_code == 12'h030, "R3 trip after unit steps", trip_code, 'h30);
    check(clr_count == 16, "R3 one clear per code", clr_count, 16);
    check(gap_err == 0, "R4 settle cycles", gap_err, 0);
    check(per_err == 0, "R4 iteration period", per_err, 0);
    exp_period = 0;

    // R9 start during a sweep is ignored
    apply('{12'h100, 1'b1, 1'b0, 16'd1, 16'd1, 12'h080, 1'b0, 1'b0});
    pulse_start();
    repeat (40) @(negedge clk);
    start_code = 12'h020;
    pulse_start();
    wait_done();
    check(trip_code == 12'h080, "R9 mid-sweep start ignored", trip_code, 'h80);
    repeat (20) @(negedge clk);
    check(done && found && trip_code == 12'h080, "R9 results held",
          {done, found}, 3);
    pulse_start();
    check(!done && !found, "R9 new start clears done", {done, found}, 0);
    wait_done();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule